// File: doc/BRIEF.md
# Serial Register Write Port

This block is a write-only slave for a three-wire serial link. It lets a host load a register file. The host drives a serial clock, a data line and an active-low load strobe. While the strobe is low, the host shifts in a 10-bit register address and then one or more 6-bit data words. Each field is sent least significant bit first.

All three serial wires pass through a short synchroniser into the system clock domain. The block finds rising edges of the serial clock there and takes one data bit at each such edge.

When a full data word has arrived, the block raises a one-cycle write strobe with the target address and the data. The next word in the same frame goes to the following address. The address wraps around at the top of the space. A word that is cut short when the strobe rises is dropped. A separate one-cycle pulse marks the end of each frame.

Top module: `tw_serial_writer`

## Requirements
- R1: A frame carries the address first and then the data words. Both are sent least significant bit first: the first bit after the strobe falls is address bit 0, and the eleventh is data bit 0.
- R2: Bits are sampled only on rising edges of the serial clock. The level of the data line around a falling edge has no effect on any write.
- R3: Each complete 6-bit data word produces exactly one `wr_en` pulse, one system clock long. The pulse carries the frame's current address on `wr_addr` and the word on `wr_data`.
- R4: A trailing word that has fewer than 6 bits when the strobe rises produces no write.
- R5: The first word of a frame is written to the received address. Each further complete word in the same frame is written to the previous address plus one.
- R6: Address increment wraps from 0x3FF to 0x000.
- R7: A frame that ends before all 10 address bits have arrived produces no write.
- R8: While the strobe is high, the bit position and the partial fields are cleared. The next frame therefore starts again at address bit 0, even after an aborted frame.
- R9: Each rising edge of the load strobe produces exactly one `frame_done` pulse, one system clock long.
- R10: While reset is active, `wr_en` and `frame_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host (asynchronous) |
| sdi | input | 1 | Serial data from host, sampled on sclk rise |
| ld_n | input | 1 | Active-low frame strobe from host |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 10 | Register address for the write |
| wr_data | output | 6 | Register data for the write |
| frame_done | output | 1 | One-cycle pulse when the strobe rises |

## Verification
Three situations are the hardest to reach from the ports. The first is a frame that stops in the middle of a field. The second is one that stops right after a partial word. The third is a run of increments that crosses the top of the address space.

The stimulus builds these deliberately. One frame ends after only five address bits and is followed by a normal frame, which shows the counters were cleared. Another frame carries three stray bits after its last full word. A third frame starts at 0x3FE so that its words land on 0x3FE, 0x3FF and 0x000.

Every bit also flips the data line just before the falling serial clock edge. A design that samples on the wrong edge would therefore write corrupted data.

// File: rtl/tw_serial_pkg.sv
package tw_serial_pkg;
   localparam int unsigned DEF_ADDR_W = 10;
   localparam int unsigned DEF_DATA_W = 6;

   typedef enum logic {
      PH_ADDR = 1'b0,
      PH_DATA = 1'b1
   } phase_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RESET_VAL}};
            else if (STAGES == 1) chain <= d;
            else chain <= {chain[STAGES-2:0], d};
         end
         assign q = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/tw_deser.sv
module tw_deser
   import tw_serial_pkg::*;
#(
   parameter int unsigned ADDR_W = DEF_ADDR_W,
   parameter int unsigned DATA_W = DEF_DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_idle,
   input  logic              bit_stb,
   input  logic              bit_val,
   output logic              addr_ok,
   output logic [ADDR_W-1:0] addr_val,
   output logic              word_ok,
   output logic [DATA_W-1:0] word_val
);
   localparam int unsigned MAX_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
   localparam int unsigned CNT_W = $clog2(MAX_W + 1);
   localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
   localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

   phase_e            phase;
   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] sh_a;
   logic [DATA_W-1:0] sh_d;
   logic [ADDR_W-1:0] nxt_a;
   logic [DATA_W-1:0] nxt_d;

   // LSB-first: each new bit enters at the top and moves down.
   assign nxt_a = {bit_val, sh_a[ADDR_W-1:1]};
   assign nxt_d = {bit_val, sh_d[DATA_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_ADDR;
         cnt      <= '0;
         sh_a     <= '0;
         sh_d     <= '0;
         addr_ok  <= 1'b0;
         addr_val <= '0;
         word_ok  <= 1'b0;
         word_val <= '0;
      end else begin
         addr_ok <= 1'b0;
         word_ok <= 1'b0;
         if (frame_idle) begin
            phase <= PH_ADDR;
            cnt   <= '0;
            sh_a  <= '0;
            sh_d  <= '0;
         end else if (bit_stb) begin
            if (phase == PH_ADDR) begin
               sh_a <= nxt_a;
               if (cnt == ADDR_LAST) begin
                  cnt      <= '0;
                  phase    <= PH_DATA;
                  addr_ok  <= 1'b1;
                  addr_val <= nxt_a;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end else begin
               sh_d <= nxt_d;
               if (cnt == DATA_LAST) begin
                  cnt      <= '0;
                  word_ok  <= 1'b1;
                  word_val <= nxt_d;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/tw_addr_ctr.sv
module tw_addr_ctr #(
   parameter int unsigned ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step,
   output logic [ADDR_W-1:0] addr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr <= '0;
      else if (load) addr <= load_val;
      else if (step) addr <= addr + 1'b1;  // natural wrap at top of space
   end
endmodule

// File: rtl/tw_serial_writer.sv
module tw_serial_writer
   import tw_serial_pkg::*;
#(
   parameter int unsigned ADDR_W      = DEF_ADDR_W,
   parameter int unsigned DATA_W      = DEF_DATA_W,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              sdi,
   input  logic              ld_n,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              frame_done
);
   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("tw_serial_writer: ADDR_W must be at least 2");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("tw_serial_writer: DATA_W must be at least 2");
      end
   endgenerate

   logic sclk_s, sdi_s, ld_s;
   logic sclk_d, ld_d;
   logic bit_stb;
   logic addr_ok, word_ok;
   logic [ADDR_W-1:0] addr_val, cur_addr;
   logic [DATA_W-1:0] word_val;

   tw_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_sclk (
      .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));
   tw_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_sdi (
      .clk(clk), .rst_n(rst_n), .d(sdi), .q(sdi_s));
   tw_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_ld (
      .clk(clk), .rst_n(rst_n), .d(ld_n), .q(ld_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         ld_d   <= 1'b1;
      end else begin
         sclk_d <= sclk_s;
         ld_d   <= ld_s;
      end
   end

   assign bit_stb = sclk_s & ~sclk_d & ~ld_s;

   tw_deser #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_deser (
      .clk(clk), .rst_n(rst_n), .frame_idle(ld_s),
      .bit_stb(bit_stb), .bit_val(sdi_s),
      .addr_ok(addr_ok), .addr_val(addr_val),
      .word_ok(word_ok), .word_val(word_val));

   tw_addr_ctr #(.ADDR_W(ADDR_W)) u_actr (
      .clk(clk), .rst_n(rst_n), .load(addr_ok), .load_val(addr_val),
      .step(word_ok), .addr(cur_addr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en      <= 1'b0;
         wr_addr    <= '0;
         wr_data    <= '0;
         frame_done <= 1'b0;
      end else begin
         wr_en      <= word_ok;
         frame_done <= ld_s & ~ld_d;
         if (word_ok) begin
            wr_addr <= cur_addr;
            wr_data <= word_val;
         end
      end
   end
endmodule

// File: rtl/tw_serial_writer_chk.sv
module tw_serial_writer_chk #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned DATA_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              frame_done
);
   logic              have_prev;
   logic [ADDR_W-1:0] prev_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_prev <= 1'b0;
         prev_addr <= '0;
      end else if (frame_done) begin
         have_prev <= 1'b0;
      end else if (wr_en) begin
         have_prev <= 1'b1;
         prev_addr <= wr_addr;
      end
   end

   // R3
   wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   // R5 R6
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && have_prev && !frame_done) |-> (wr_addr == ADDR_W'(prev_addr + 1'b1)));

   // R9
   frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);

   // R3
   data_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !$isunknown(wr_data));

   // R10
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reset_quiet_chk: assert (!wr_en && !frame_done);
      end
   end
endmodule

bind tw_serial_writer tw_serial_writer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .frame_done(frame_done));

// File: tb/tw_serial_writer_tb.sv
module tw_serial_writer_tb;
   localparam int HALF = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0;
   logic       sdi = 1'b0;
   logic       ld_n = 1'b1;
   logic       wr_en;
   logic [9:0] wr_addr;
   logic [5:0] wr_data;
   logic       frame_done;

   typedef struct packed { logic [9:0] a; logic [5:0] d; } item_t;
   item_t exp_q[$];
   int    checks = 0;
   int    errors = 0;
   int    fd_cnt = 0;
   int    fd_exp = 0;
   string cur_req = "R3";
   bit    done = 1'b0;

   always #5 clk = ~clk;

   tw_serial_writer u_dut (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .ld_n(ld_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .frame_done(frame_done));

   // Monitor: pops the scoreboard on every write strobe
   always @(negedge clk) begin
      if (rst_n && wr_en) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL %s: unexpected write addr=%h data=%h expected none",
                     cur_req, wr_addr, wr_data);
         end else begin
            item_t e;
            e = exp_q.pop_front();
            if (wr_addr !== e.a || wr_data !== e.d) begin
               errors++;
               $display("FAIL %s: write addr=%h data=%h expected addr=%h data=%h",
                        cur_req, wr_addr, wr_data, e.a, e.d);
            end
         end
      end
      if (rst_n && frame_done) fd_cnt++;
   end

   task automatic send_bit(input logic b);
      @(negedge clk);
      sdi  = b;
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sdi = ~b;  // R2: level around the falling edge must not matter
      @(negedge clk);
      sclk = 1'b0;
   endtask

   task automatic start_frame();
      @(negedge clk);
      ld_n = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic end_frame(input string req);
      repeat (3) @(negedge clk);
      ld_n = 1'b1;
      fd_exp++;
      repeat (12) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL %s: %0d expected writes missing, expected 0", req, exp_q.size());
         exp_q.delete();
      end
      // R9: one frame_done pulse per strobe rise
      checks++;
      if (fd_cnt != fd_exp) begin
         errors++;
         $display("FAIL R9: frame_done count=%0d expected %0d", fd_cnt, fd_exp);
      end
   endtask

   // R1: address then data, each LSB first
   task automatic send_frame(input logic [9:0] a, input int nw, input logic [5:0] d0,
                             input int extra, input string req);
      logic [9:0] ca;
      logic [5:0] cd;
      cur_req = req;
      start_frame();
      for (int i = 0; i < 10; i++) send_bit(a[i]);
      ca = a;
      cd = d0;
      for (int w = 0; w < nw; w++) begin
         exp_q.push_back({ca, cd});
         for (int i = 0; i < 6; i++) send_bit(cd[i]);
         ca = ca + 10'd1;
         cd = cd + 6'd13;
      end
      for (int i = 0; i < extra; i++) send_bit(i[0]);
      end_frame(req);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R10: outputs quiet in reset
      checks++;
      if (wr_en !== 1'b0 || frame_done !== 1'b0) begin
         errors++;
         $display("FAIL R10: wr_en=%b frame_done=%b expected 0 0", wr_en, frame_done);
      end
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      send_frame(10'h05A, 1, 6'h2B, 0, "R1");
      send_frame(10'h123, 4, 6'h15, 0, "R5");
      send_frame(10'h3FE, 3, 6'h3F, 0, "R6");
      send_frame(10'h010, 2, 6'h01, 3, "R4");
      // R7: frame cut inside the address
      cur_req = "R7";
      start_frame();
      for (int i = 0; i < 5; i++) send_bit(1'b1);
      end_frame("R7");
      // R8: next frame starts again at address bit 0
      send_frame(10'h2C5, 2, 6'h2A, 0, "R8");
      send_frame(10'h000, 1, 6'h00, 5, "R2");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule